// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block generates the reset seen by a small processor core. It merges four reset causes: an external active-low pin that may be shared with general I/O, a low-supply detector level, and a watchdog expiry pulse, whose effect depends on whether the core is powered down. The block's own power-on reset, `por_n`, also starts a sequence. From these causes it drives two outputs. `full_rst_n` is a level that stays low through a delay interval and then a start-up interval. `partial_rst` is a one-cycle strobe that clears only the program counter and stack pointer of a core woken from power-down.

Two configuration inputs choose whether the pin acts as a reset and whether the low-supply detector may cause one. A supply dip resets the core only when it lasts longer than a parameterised number of cycles. The block also keeps a timeout flag. This flag tells software after the event whether the watchdog caused the restart.

Top module: `reset_sequencer`

## Requirements
- R1: With `pin_mode_rst`=1, a low level on `pin_raw_n` passes through a two-flop synchronizer. Each clock edge that sees the synchronized level low starts a full reset. `full_rst_n` therefore goes low on the third edge after the pin is first sampled low.
- R2: With `pin_mode_rst`=0, the level on `pin_raw_n` never causes a reset.
- R3: With `lv_en`=0, `lv_sense` never causes a reset.
- R4: With `lv_en`=1, a reset starts on the edge that sees `lv_sense` high for the (LV_QUAL_CYC+1)-th consecutive cycle. Every later edge with `lv_sense` still high starts it again. An episode of LV_QUAL_CYC cycles or fewer has no effect.
- R5: After the last edge that starts a full reset, `full_rst_n` stays low for DELAY_CYC+SST_CYC cycles and then goes high. A new full-reset cause during a sequence restarts the count from zero.
- R6: `wdt_tmo` with `pwr_down`=0 starts a full reset exactly as the pin does, and `tmo_flag` reads 1 from the next cycle. The flag keeps that value through the reset.
- R7: `wdt_tmo` with `pwr_down`=1, seen while no full sequence runs, leaves `full_rst_n` high. Exactly SST_CYC edges later it raises `partial_rst` for exactly one cycle, and it sets `tmo_flag`.
- R8: A pin or low-supply reset cause clears `tmo_flag`. A `wdt_clr` strobe clears it. `wdt_tmo` wins over `wdt_clr` when both arrive in the same cycle.
- R9: A full-reset cause arriving with a power-down expiry takes precedence: no `partial_rst` is produced. A power-down expiry during a running full sequence neither shortens it nor produces `partial_rst`.
- R10: While `por_n` is low, `full_rst_n`=0, `partial_rst`=0 and `tmo_flag`=0. `full_rst_n` rises DELAY_CYC+SST_CYC cycles after `por_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset of the block |
| pin_raw_n | input | 1 | Unsynchronized external reset pin, active low |
| pin_mode_rst | input | 1 | 1: pin acts as reset, 0: pin is general I/O |
| lv_sense | input | 1 | Low-supply detector level, high while supply is low |
| lv_en | input | 1 | Enables low-supply reset |
| wdt_tmo | input | 1 | Watchdog expiry pulse |
| pwr_down | input | 1 | Core is in power-down |
| wdt_clr | input | 1 | Clear-watchdog strobe, clears the timeout flag |
| full_rst_n | output | 1 | Full internal reset, active low |
| partial_rst | output | 1 | One-cycle strobe clearing program counter and stack pointer |
| tmo_flag | output | 1 | Watchdog timeout flag |

## Verification
The bench builds the block with DELAY_CYC=3, SST_CYC=4 and LV_QUAL_CYC=5. These short windows let it sweep every low-supply episode length from 1 to 8 with the enable both off and on, crossing the qualification threshold from both sides. They also let it sweep several pin hold lengths, and restart a sequence in its delay phase. The same settings keep collision cases short: a power-down expiry arriving with or after a full-reset cause, and an expiry meeting a clear strobe in one cycle. Release and pulse cycles are predicted from the parameter sums.

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int DELAY_CYC   = 64,
  parameter int SST_CYC     = 1024,
  parameter int LV_QUAL_CYC = 256
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_raw_n,
  input  logic pin_mode_rst,
  input  logic lv_sense,
  input  logic lv_en,
  input  logic wdt_tmo,
  input  logic pwr_down,
  input  logic wdt_clr,
  output logic full_rst_n,
  output logic partial_rst,
  output logic tmo_flag
);
  localparam int SEQ_MAX = (DELAY_CYC > SST_CYC) ? DELAY_CYC : SST_CYC;
  localparam int CW = $clog2(SEQ_MAX + 1);
  localparam int LW = $clog2(LV_QUAL_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_DELAY, S_SST, S_PDSST} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [LW-1:0] lv_cnt;
  logic pin_s1, pin_s2;

  wire pin_hit  = pin_mode_rst & ~pin_s2;
  wire lv_full  = (lv_cnt == LW'(LV_QUAL_CYC));
  wire lv_hit   = lv_en & lv_sense & lv_full;
  wire wdt_full = wdt_tmo & ~pwr_down;
  wire wdt_part = wdt_tmo & pwr_down;
  wire full_hit = pin_hit | lv_hit | wdt_full;
  wire part_go  = wdt_part & ~full_hit & (st == S_IDLE || st == S_PDSST);
  wire seq_last = (st == S_DELAY) ? (cnt == CW'(DELAY_CYC - 1))
                                  : (cnt == CW'(SST_CYC - 1));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      pin_s1 <= 1'b1;
      pin_s2 <= 1'b1;
    end else begin
      pin_s1 <= pin_raw_n;
      pin_s2 <= pin_s1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)
      lv_cnt <= '0;
    else if (lv_en & lv_sense) begin
      if (!lv_full) lv_cnt <= lv_cnt + 1'b1;
    end else
      lv_cnt <= '0;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      st          <= S_DELAY;
      cnt         <= '0;
      full_rst_n  <= 1'b0;
      partial_rst <= 1'b0;
    end else begin
      partial_rst <= 1'b0;
      if (full_hit) begin
        st         <= S_DELAY;
        cnt        <= '0;
        full_rst_n <= 1'b0;
      end else if (part_go) begin
        st  <= S_PDSST;
        cnt <= '0;
      end else begin
        case (st)
          S_DELAY:
            if (seq_last) begin
              st  <= S_SST;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          S_SST:
            if (seq_last) begin
              st         <= S_IDLE;
              cnt        <= '0;
              full_rst_n <= 1'b1;
            end else cnt <= cnt + 1'b1;
          S_PDSST:
            if (seq_last) begin
              st          <= S_IDLE;
              cnt         <= '0;
              partial_rst <= 1'b1;
            end else cnt <= cnt + 1'b1;
          default: cnt <= '0;
        endcase
      end
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                tmo_flag <= 1'b0;
    else if (pin_hit | lv_hit) tmo_flag <= 1'b0;
    else if (wdt_tmo)          tmo_flag <= 1'b1;
    else if (wdt_clr)          tmo_flag <= 1'b0;

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!por_n)
    partial_rst |=> !partial_rst);

  assert_pd_keeps_full_R7: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_part && !full_hit && full_rst_n && st == S_IDLE) |=> full_rst_n);

  assert_no_partial_in_full_R9: assert property (@(posedge clk) disable iff (!por_n)
    partial_rst |-> full_rst_n);

  assert_wdt_full_R6: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_full && !pin_hit && !lv_hit) |=> (!full_rst_n && tmo_flag));

  assert_src_clears_flag_R8: assert property (@(posedge clk) disable iff (!por_n)
    (pin_hit || lv_hit) |=> !tmo_flag);

  assert_release_clean_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(full_rst_n) |-> !$past(full_hit));
endmodule

// File: tb/reset_sequencer_tb.sv
module reset_sequencer_tb_top;
  localparam int D = 3;
  localparam int S = 4;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic por_n, pin_raw_n, pin_mode_rst, lv_sense, lv_en, wdt_tmo, pwr_down, wdt_clr;
  logic full_rst_n, partial_rst, tmo_flag;

  reset_sequencer #(.DELAY_CYC(D), .SST_CYC(S), .LV_QUAL_CYC(Q)) dut_i (
    .clk(clk), .por_n(por_n), .pin_raw_n(pin_raw_n), .pin_mode_rst(pin_mode_rst),
    .lv_sense(lv_sense), .lv_en(lv_en), .wdt_tmo(wdt_tmo), .pwr_down(pwr_down),
    .wdt_clr(wdt_clr), .full_rst_n(full_rst_n), .partial_rst(partial_rst),
    .tmo_flag(tmo_flag));

  always #4 clk = ~clk;

  int cyc = 0;
  int n_tests = 0, n_fail = 0;
  int n_fall = 0, fall_cyc = -1, rise_cyc = -1;
  int n_pulse = 0, pulse_cyc = -1, wide = 0;
  logic prev_rst = 1'b0, prev_part = 1'b0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (prev_rst && !full_rst_n) begin n_fall++; fall_cyc = cyc; end
    if (!prev_rst && full_rst_n) rise_cyc = cyc;
    prev_rst = full_rst_n;
    if (partial_rst) begin
      n_pulse++;
      pulse_cyc = cyc;
      if (prev_part) wide++;
    end
    prev_part = partial_rst;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic nxt(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wdt_pulse();
    wdt_tmo = 1'b1; nxt(); wdt_tmo = 1'b0;
  endtask

  int t0, f, p;

  initial begin
    por_n = 0; pin_raw_n = 1; pin_mode_rst = 1; lv_sense = 0; lv_en = 1;
    wdt_tmo = 0; pwr_down = 0; wdt_clr = 0;
    nxt(2);
    chk("R10 rst low", full_rst_n, 0);
    chk("R10 partial low", partial_rst, 0);
    chk("R10 flag low", tmo_flag, 0);
    t0 = cyc; por_n = 1;
    nxt(20);
    chk("R10 release cycle", rise_cyc, t0 + D + S);

    for (int L = 1; L <= 4; L++) begin
      t0 = cyc; pin_raw_n = 0; nxt(L); pin_raw_n = 1;
      nxt(20);
      chk("R1 pin fall", fall_cyc, t0 + 3);
      chk("R5 pin release", rise_cyc, t0 + L + 2 + D + S);
    end

    pin_mode_rst = 0; f = n_fall;
    pin_raw_n = 0; nxt(6); pin_raw_n = 1; nxt(20);
    chk("R2 gpio pin ignored", n_fall - f, 0);
    chk("R2 rst stays high", full_rst_n, 1);
    pin_mode_rst = 1; nxt(4);

    for (int en = 0; en <= 1; en++)
      for (int L = 1; L <= 8; L++) begin
        int exp;
        lv_en = en[0]; f = n_fall; t0 = cyc;
        lv_sense = 1; nxt(L); lv_sense = 0; nxt(20);
        exp = (en == 1 && L > Q) ? 1 : 0;
        chk(en ? "R4 lv qualify" : "R3 lv disabled", n_fall - f, exp);
        if (exp == 1) begin
          chk("R4 lv fall", fall_cyc, t0 + Q + 1);
          chk("R5 lv release", rise_cyc, t0 + L + D + S);
        end
      end
    lv_en = 1;

    t0 = cyc; wdt_pulse();
    chk("R6 flag set", tmo_flag, 1);
    nxt(20);
    chk("R6 wdt fall", fall_cyc, t0 + 1);
    chk("R6 wdt release", rise_cyc, t0 + 1 + D + S);
    chk("R6 flag kept", tmo_flag, 1);

    wdt_clr = 1; nxt(); wdt_clr = 0;
    chk("R8 clr strobe", tmo_flag, 0);
    wdt_pulse(); nxt(20);
    pin_raw_n = 0; nxt(); pin_raw_n = 1; nxt(20);
    chk("R8 pin clears flag", tmo_flag, 0);
    wdt_pulse(); nxt(20);
    lv_sense = 1; nxt(Q + 2); lv_sense = 0; nxt(20);
    chk("R8 lv clears flag", tmo_flag, 0);

    pwr_down = 1; f = n_fall; p = n_pulse; t0 = cyc;
    wdt_pulse(); nxt(20);
    chk("R7 no full reset", n_fall - f, 0);
    chk("R7 one pulse", n_pulse - p, 1);
    chk("R7 pulse cycle", pulse_cyc, t0 + 1 + S);
    chk("R7 pulse width", wide, 0);
    chk("R7 flag set", tmo_flag, 1);

    wdt_clr = 1; nxt(); wdt_clr = 0;
    wdt_tmo = 1; wdt_clr = 1; nxt(); wdt_tmo = 0; wdt_clr = 0;
    chk("R8 expire beats clear", tmo_flag, 1);
    nxt(20);

    pwr_down = 0; f = n_fall; t0 = cyc;
    wdt_pulse(); nxt(); wdt_pulse(); nxt(20);
    chk("R5 restart one fall", n_fall - f, 1);
    chk("R5 restart release", rise_cyc, t0 + 3 + D + S);

    pwr_down = 1; p = n_pulse; t0 = cyc;
    pin_raw_n = 0; nxt(); pin_raw_n = 1; nxt();
    wdt_pulse(); nxt(20);
    chk("R9 same-cycle fall", fall_cyc, t0 + 3);
    chk("R9 same-cycle no pulse", n_pulse - p, 0);
    chk("R9 pin wins flag", tmo_flag, 0);

    pwr_down = 0; p = n_pulse; t0 = cyc;
    wdt_pulse(); nxt();
    pwr_down = 1; wdt_pulse(); nxt(20);
    chk("R9 mid-seq release", rise_cyc, t0 + 1 + D + S);
    chk("R9 mid-seq no pulse", n_pulse - p, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule